// File: doc/BRIEF.md
# Delay-Line Phase Fraction Decoder

This block turns the snapshot of a tapped oscillator delay line, frozen by a reference clock edge, into the time from that reference edge to the next rising oscillator edge. The result is a fraction of one oscillator period. Adjacent taps are one inverter delay apart, so every odd tap carries an inverted copy of the clock. The block first restores the true clock polarity on those taps. It then finds the first rising and the first falling transition in the vector. Their spacing gives half the oscillator period, measured in taps at the moment of capture.

The tap index of the rising transition is divided by the measured period in a serial restoring divider. The divider yields an unsigned F-bit fraction after a fixed number of cycles and raises a one-cycle done strobe. If a snapshot lacks either transition, no period can be measured. The block then pulses an invalid flag and leaves every output unchanged. A phase-domain loop uses the fraction to refine its whole-cycle edge count below one oscillator period.

Top module: `tdc_frac_norm`

## Requirements
- R1: While reset is asserted, and in the cycle after it is released, `rise_tap`, `per_tap` and `frac` read 0, and `frac_done` and `samp_bad` are low.
- R2: Bit i of `samp_vec` is delay tap i. Bits with odd i hold the inverted clock and are complemented before decoding, so an all-zero vector reads as true samples 0,1,0,1,... (rise at tap 1, period 2).
- R3: `rise_tap` is the lowest index i (1 to N-1) whose true sample is 1 while the true sample at i-1 is 0.
- R4: `per_tap` is twice the distance between `rise_tap` and the lowest index i whose true sample is 0 while the true sample at i-1 is 1.
- R5: When `rise_tap` < `per_tap`, `frac` equals floor(`rise_tap`·2^F / `per_tap`).
- R6: When `rise_tap` >= `per_tap`, `frac` saturates to all ones.
- R7: An accepted strobe updates `rise_tap` and `per_tap` at the same clock edge. `frac` updates and `frac_done` pulses high for one cycle exactly F edges later.
- R8: A strobed vector that lacks either transition raises `samp_bad` for one cycle after the strobe edge and changes no other output.
- R9: A strobe that arrives while a division is in progress is ignored. The running result and its timing are unaffected, and no extra done pulse follows.
- R10: `frac` changes only in a cycle in which `frac_done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| samp_stb | input | 1 | Marks a new delay-line snapshot on `samp_vec` |
| samp_vec | input | N | Captured tap states, tap 0 in bit 0 |
| rise_tap | output | $clog2(N) | Tap index of the first rising transition |
| per_tap | output | $clog2(N)+1 | Oscillator period in taps |
| frac | output | F | Rising-edge delay as a fraction of the period |
| frac_done | output | 1 | One-cycle pulse when `frac` is updated |
| samp_bad | output | 1 | One-cycle pulse for a snapshot without both transitions |

## Verification
The main stimulus is a sweep over every half-period from 1 to 20 taps, combined with every phase offset inside that period. Each sweep vector is built from an ideal clock waveform, with the odd taps inverted. Long periods push one of the transitions past the last tap, which separates the invalid path from correct decoding. An offset of zero places the rising edge exactly one period in, which exercises saturation. The other offsets tell apart errors in rise position, period and division rounding. A single all-zero vector isolates the odd-tap polarity fix, and a strobe injected in the middle of a division shows whether the busy lockout holds.

// File: rtl/tdc_frac_norm.sv
module tdc_frac_norm #(
  parameter int N = 32,
  parameter int F = 8,
  localparam int PW = $clog2(N),
  localparam int W  = PW + 1,
  localparam int CW = $clog2(F + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          samp_stb,
  input  logic [N-1:0]  samp_vec,
  output logic [PW-1:0] rise_tap,
  output logic [W-1:0]  per_tap,
  output logic [F-1:0]  frac,
  output logic          frac_done,
  output logic          samp_bad
);

  logic [N-1:0] clk_true;

  for (genvar g = 0; g < N; g++) begin : g_pol
    if (g % 2 == 1) begin : g_odd
      assign clk_true[g] = ~samp_vec[g];
    end else begin : g_even
      assign clk_true[g] = samp_vec[g];
    end
  end

  logic [PW-1:0] r_pos, f_pos;
  logic          r_ok, f_ok;

  always_comb begin
    r_pos = '0;
    f_pos = '0;
    r_ok  = 1'b0;
    f_ok  = 1'b0;
    for (int i = N - 1; i >= 1; i--) begin
      if (!clk_true[i-1] && clk_true[i]) begin
        r_ok  = 1'b1;
        r_pos = PW'(i);
      end
      if (clk_true[i-1] && !clk_true[i]) begin
        f_ok  = 1'b1;
        f_pos = PW'(i);
      end
    end
  end

  wire [PW-1:0] half   = (r_pos > f_pos) ? r_pos - f_pos : f_pos - r_pos;
  wire [W-1:0]  period = {half, 1'b0};
  wire          snap_ok = r_ok & f_ok;

  logic          busy, sat;
  logic [CW-1:0] cnt;
  logic [W-1:0]  rem;
  logic [F-1:0]  quo;

  wire           accept = samp_stb & ~busy;
  wire [W:0]     rem_sh = {rem, 1'b0};
  wire           ge     = rem_sh >= {1'b0, per_tap};
  wire [W:0]     rem_nx = ge ? rem_sh - {1'b0, per_tap} : rem_sh;
  wire [F-1:0]   quo_nx = {quo[F-2:0], ge};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      sat       <= 1'b0;
      cnt       <= '0;
      rem       <= '0;
      quo       <= '0;
      rise_tap  <= '0;
      per_tap   <= '0;
      frac      <= '0;
      frac_done <= 1'b0;
      samp_bad  <= 1'b0;
    end else begin
      frac_done <= 1'b0;
      samp_bad  <= 1'b0;
      if (accept) begin
        if (snap_ok) begin
          rise_tap <= r_pos;
          per_tap  <= period;
          rem      <= W'(r_pos);
          sat      <= W'(r_pos) >= period;
          quo      <= '0;
          cnt      <= '0;
          busy     <= 1'b1;
        end else begin
          samp_bad <= 1'b1;
        end
      end else if (busy) begin
        rem <= rem_nx[W-1:0];
        quo <= quo_nx;
        cnt <= cnt + 1'b1;
        if (cnt == CW'(F - 1)) begin
          busy      <= 1'b0;
          frac_done <= 1'b1;
          frac      <= sat ? '1 : quo_nx;
        end
      end
    end
  end

  p_bad_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
    samp_bad |-> $stable(rise_tap) && $stable(per_tap) && $stable(frac) && !frac_done);

  p_frac_only_on_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !frac_done |-> $stable(frac));

  p_saturate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (frac_done && (W'(rise_tap) >= per_tap)) |-> (frac == '1));

  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    frac_done |=> !frac_done);

  p_done_after_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    frac_done |-> $past(busy) && !busy);

  p_tap_moves_on_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rise_tap) |-> $past(samp_stb) && !$past(busy));

  p_period_nonzero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    frac_done |-> per_tap != '0);

endmodule

// File: tb/tdc_frac_norm_tb.sv
module tdc_frac_norm_tb_top;
  localparam int N  = 32;
  localparam int F  = 8;
  localparam int PW = $clog2(N);
  localparam int W  = PW + 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          samp_stb = 1'b0;
  logic [N-1:0]  samp_vec = '0;
  logic [PW-1:0] rise_tap;
  logic [W-1:0]  per_tap;
  logic [F-1:0]  frac;
  logic          frac_done;
  logic          samp_bad;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;
  int e_rise = 0, e_per = 0, e_frac = 0;

  always #5 clk = ~clk;

  tdc_frac_norm #(.N(N), .F(F)) dut_i (
    .clk(clk), .rst_n(rst_n), .samp_stb(samp_stb), .samp_vec(samp_vec),
    .rise_tap(rise_tap), .per_tap(per_tap), .frac(frac),
    .frac_done(frac_done), .samp_bad(samp_bad));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=%0d expected=0", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic run_vec(input logic [N-1:0] v, input bit ok_exp,
                         input int er, input int ep, input string tag);
    int ef;
    @(negedge clk);
    samp_vec = v;
    samp_stb = 1'b1;
    @(negedge clk);
    samp_stb = 1'b0;
    if (!ok_exp) begin
      chk(samp_bad == 1'b1, {tag, " R8 bad flag"}, int'(samp_bad), 1);
      chk(rise_tap == e_rise && per_tap == e_per && frac == e_frac,
          {tag, " R8 hold"}, int'(rise_tap), e_rise);
      return;
    end
    ef = (er >= ep) ? (1 << F) - 1 : (er << F) / ep;
    chk(rise_tap == er, {tag, " R3 rise"}, int'(rise_tap), er);
    chk(per_tap == ep, {tag, " R4 period"}, int'(per_tap), ep);
    for (int k = 1; k <= F; k++) begin
      @(negedge clk);
      if (k < F) chk(frac_done == 1'b0, {tag, " R7 early done"}, int'(frac_done), 0);
    end
    chk(frac_done == 1'b1, {tag, " R7 done"}, int'(frac_done), 1);
    chk(frac == ef, er >= ep ? {tag, " R6 sat"} : {tag, " R5 frac"}, int'(frac), ef);
    e_rise = er; e_per = ep; e_frac = ef;
  endtask

  task automatic sweep_case(input int h, input int o);
    int p, er, ef_t;
    logic [N-1:0] v;
    p = 2 * h;
    for (int i = 0; i < N; i++) v[i] = (((i + o) % p) < h) ^ (i % 2 == 1);
    er = (p - o) % p;   if (er == 0) er = p;
    ef_t = (h - o + p) % p; if (ef_t == 0) ef_t = p;
    run_vec(v, (er < N) && (ef_t < N), er, p, "sweep");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(rise_tap == 0 && per_tap == 0 && frac == 0, "R1 reset outputs", int'(frac), 0);
    chk(frac_done == 0 && samp_bad == 0, "R1 reset flags", int'(frac_done), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(rise_tap == 0 && frac == 0 && frac_done == 0, "R1 after release", int'(rise_tap), 0);

    run_vec('0, 1'b1, 1, 2, "R2 polarity");

    run_vec({(N/2){2'b01}}, 1'b0, 0, 0, "R8 flat");

    for (int h = 1; h <= 20; h++)
      for (int o = 0; o < 2 * h; o++)
        sweep_case(h, o);

    begin
      logic [N-1:0] v;
      for (int i = 0; i < N; i++) v[i] = (((i + 3) % 10) < 5) ^ (i % 2 == 1);
      @(negedge clk);
      samp_vec = v;
      samp_stb = 1'b1;
      @(negedge clk);
      samp_stb = 1'b0;
      for (int k = 1; k <= F; k++) begin
        if (k == 3) begin
          samp_vec = '0;
          samp_stb = 1'b1;
        end
        @(negedge clk);
        samp_stb = 1'b0;
        if (k < F) chk(frac_done == 0 && rise_tap == 7, "R9 busy ignore", int'(rise_tap), 7);
      end
      chk(frac_done == 1 && frac == 179, "R9 result kept", int'(frac), 179);
      chk(per_tap == 10, "R9 period kept", int'(per_tap), 10);
      for (int k = 0; k < F + 2; k++) begin
        @(negedge clk);
        chk(frac_done == 0 && frac == 179, "R10 no extra done", int'(frac_done), 0);
      end
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule